// File: doc/BRIEF.md
# Programmable Memory Wait-State Generator

This block stretches processor bus cycles that land on slow memory-mapped peripherals. It watches the bus address and the access strobe. When a new access begins and its address falls in one of four decoded device regions, the region's wait count is read from a small count table. That count is loaded into a down-counter in the same step, and `ready` stays low until the count has run out. Accesses that miss every region, or hit a region whose count is zero, complete with no inserted cycles.

The count table has no reset value. It is filled while reset is held: during reset the table index comes from a dedicated initialization index input instead of the region decoder, and a write enable stores one count per clock. Once reset is released the table is read-only. The counter width is a parameter. The default of 4 bits gives 0 to 15 wait states, and a wider setting serves devices with access times near a microsecond.

Top module: `wsg_top`

## Requirements
- R1: While `rstN` is low, `ready` is high and the wait counter is cleared.
- R2: The counter is loaded only in the first cycle of an access, meaning the cycle where `busStrobe` is high after being low. Holding `busStrobe` high afterwards never reloads it, and `ready` stays high once the wait has expired.
- R3: An access whose region holds count N > 0 drives `ready` low for exactly N consecutive cycles, starting in the strobe's first cycle. `ready` is high in the cycle that follows.
- R4: An access to a region holding count 0 sees `ready` high in its first cycle.
- R5: An access matching no region sees `ready` high in its first cycle.
- R6: Region i matches when `(busAddr[15:12] & MASK_i) == BASE_i`. The defaults are region 0 = base 8/mask F, region 1 = base 9/mask F, region 2 = base A/mask E, and region 3 = base 8/mask 8. When several regions match, the lowest index wins.
- R7: While `rstN` is low, `initWrEn` stores `initCount` into entry `initIdx`. While `rstN` is high, `initWrEn` has no effect on the table.
- R8: A new access start always overrides a count still in progress. A hit reloads the counter with the new region's count. A miss clears it, so `ready` rises at once.
- R9: Counts span the full counter width. With the default width of 4, a count of 15 gives 15 wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; also the table-initialization window |
| busAddr | input | ADDR_W | Bus address; the upper DEC_W bits are decoded |
| busStrobe | input | 1 | Access strobe, high for the duration of a bus cycle |
| initWrEn | input | 1 | Table write enable, honoured only during reset |
| initIdx | input | 2 | Table entry selected during reset |
| initCount | input | CNT_W | Wait count written to the table |
| ready | output | 1 | High when the current access may complete |

## Verification
On every cycle, the assertions check these rules: the load pulse lasts one cycle and needs the strobe; the counter steps down by one while it is not being loaded; `ready` stays low whenever a count is pending; and a miss forces `ready` high and clears the counter. Only the bench scenarios can show the end-to-end facts. These are the exact wait length taken from the table contents, the region priority, the rejection of table writes after reset, and the override of a running count by a fresh access.

// File: rtl/wsg_pkg.sv
`timescale 1ns/1ps
package wsg_pkg;
  localparam int NUM_REGIONS = 4;
  localparam int IDX_W = $clog2(NUM_REGIONS);

  typedef struct packed {
    logic             load;   // one-cycle access-start pulse
    logic             hit;    // decoded address falls in a region
    logic [IDX_W-1:0] region; // winning region index
  } wsgCtl_t;
endpackage

// File: rtl/wsg_ctrl.sv
`timescale 1ns/1ps
module wsg_ctrl
  import wsg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEC_W  = 4,
  parameter logic [NUM_REGIONS*DEC_W-1:0] REGION_BASE = 16'h8A98,
  parameter logic [NUM_REGIONS*DEC_W-1:0] REGION_MASK = 16'h8EFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busStrobe,
  output wsgCtl_t           ctl
);
  logic strobeDly;
  logic [NUM_REGIONS-1:0] match;
  logic [DEC_W-1:0] addrTag;

  assign addrTag = busAddr[ADDR_W-1 -: DEC_W];

  // delayed copy of the strobe; XOR with the live strobe marks its edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobeDly <= 1'b0;
    else       strobeDly <= busStrobe;
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gRegion
    assign match[g] = (addrTag & REGION_MASK[g*DEC_W +: DEC_W])
                      == REGION_BASE[g*DEC_W +: DEC_W];
  end

  // lowest matching index wins: scan downward so it is assigned last
  always_comb begin
    ctl.load   = rstN & busStrobe & (busStrobe ^ strobeDly);
    ctl.hit    = 1'b0;
    ctl.region = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (match[i]) begin
        ctl.hit    = 1'b1;
        ctl.region = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/wsg_datapath.sv
`timescale 1ns/1ps
module wsg_datapath
  import wsg_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  wsgCtl_t          ctl,
  input  logic             initWrEn,
  input  logic [IDX_W-1:0] initIdx,
  input  logic [CNT_W-1:0] initCount,
  output logic             ready,
  output logic [CNT_W-1:0] waitCnt
);
  logic [CNT_W-1:0] countTbl [NUM_REGIONS];
  logic [IDX_W-1:0] tblIdx;
  logic [CNT_W-1:0] selCount;
  logic [CNT_W-1:0] loadVal;
  logic             needWait;

  // table index is switched to the init port while reset is held
  assign tblIdx   = rstN ? ctl.region : initIdx;
  assign selCount = countTbl[tblIdx];

  always_ff @(posedge clk) begin
    if (!rstN && initWrEn) countTbl[tblIdx] <= initCount;
  end

  assign needWait = ctl.hit && (selCount != '0);
  // the load cycle itself is the first wait cycle, so N-1 is stored
  assign loadVal  = needWait ? CNT_W'(selCount - 1'b1) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                waitCnt <= '0;
    else if (ctl.load)        waitCnt <= loadVal;
    else if (waitCnt != '0)   waitCnt <= CNT_W'(waitCnt - 1'b1);
  end

  assign ready = ctl.load ? !needWait : (waitCnt == '0);
endmodule

// File: rtl/wsg_top.sv
`timescale 1ns/1ps
module wsg_top
  import wsg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEC_W  = 4,
  parameter int CNT_W  = 4,
  parameter logic [NUM_REGIONS*DEC_W-1:0] REGION_BASE = 16'h8A98,
  parameter logic [NUM_REGIONS*DEC_W-1:0] REGION_MASK = 16'h8EFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busStrobe,
  input  logic              initWrEn,
  input  logic [IDX_W-1:0]  initIdx,
  input  logic [CNT_W-1:0]  initCount,
  output logic              ready
);
  wsgCtl_t          ctl;
  logic [CNT_W-1:0] waitCnt;

  wsg_ctrl #(
    .ADDR_W(ADDR_W), .DEC_W(DEC_W),
    .REGION_BASE(REGION_BASE), .REGION_MASK(REGION_MASK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busStrobe(busStrobe), .ctl(ctl)
  );

  wsg_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .initWrEn(initWrEn), .initIdx(initIdx), .initCount(initCount),
    .ready(ready), .waitCnt(waitCnt)
  );
endmodule

// File: rtl/wsg_checker.sv
`timescale 1ns/1ps
module wsg_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             busStrobe,
  input logic             load,
  input logic             hit,
  input logic [CNT_W-1:0] waitCnt,
  input logic             ready
);
  AST_RESET_READY: assert property (@(posedge clk) !rstN |-> ready); // R1
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    load |=> !load); // R2
  AST_LOAD_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    load |-> busStrobe); // R2
  AST_COUNT_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (!load && waitCnt != '0) |=> waitCnt == CNT_W'($past(waitCnt) - 1'b1)); // R3
  AST_PENDING_HOLDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (!load && waitCnt != '0) |-> !ready); // R3
  AST_MISS_NO_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (load && !hit) |-> ready); // R5
  AST_MISS_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (load && !hit) |=> waitCnt == '0); // R8
endmodule

bind wsg_top wsg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .busStrobe(busStrobe),
  .load(ctl.load), .hit(ctl.hit), .waitCnt(waitCnt), .ready(ready)
);

// File: tb/wsg_top_bench.sv
`timescale 1ns/1ps
module wsg_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic [15:0] busAddr = '0;
  logic        busStrobe = 1'b0;
  logic        initWrEn = 1'b0;
  logic [1:0]  initIdx = '0;
  logic [3:0]  initCount = '0;
  logic        ready;

  int nChecks = 0;
  int nFails  = 0;
  int tbl [4];
  bit finished = 1'b0;

  // R6 region definitions, written independently of the design
  int regBase [4] = '{8, 9, 10, 8};
  int regMask [4] = '{15, 15, 14, 8};

  wsg_top u_wsg_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busStrobe(busStrobe),
    .initWrEn(initWrEn), .initIdx(initIdx), .initCount(initCount), .ready(ready)
  );

  always #2.5 clk = ~clk;

  function automatic int expWaits(input logic [15:0] a);
    int tag = int'(a[15:12]);
    for (int i = 0; i < 4; i++)
      if ((tag & regMask[i]) == regBase[i]) return tbl[i];
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic resetLoad(input int c0, input int c1, input int c2, input int c3);
    int vals [4];
    vals = '{c0, c1, c2, c3};
    @(negedge clk); rstN = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      initWrEn = 1'b1; initIdx = 2'(i); initCount = 4'(vals[i]);
      tbl[i] = vals[i];
    end
    @(negedge clk); initWrEn = 1'b0;
    #1 check(ready == 1'b1, "R1", int'(ready), 1);
    @(negedge clk); rstN = 1'b1;
  endtask

  // strobe rises at a negedge; ready is sampled 1 ns after each negedge
  task automatic doAccess(input logic [15:0] a, input int holdAfter, input string req);
    int waits = 0;
    int exp = expWaits(a);
    bit ok = 1'b1;
    @(negedge clk); busAddr = a; busStrobe = 1'b1;
    #1;
    while (!ready && waits < 40) begin
      waits++;
      @(negedge clk); #1;
    end
    check(waits == exp, req, waits, exp);
    for (int k = 0; k < holdAfter; k++) begin
      @(negedge clk); #1;
      if (!ready) ok = 1'b0;
    end
    if (holdAfter > 0) check(ok, "R2", int'(ok), 1);
    @(negedge clk); busStrobe = 1'b0;
  endtask

  // start a long wait, break it after three cycles with a new access
  task automatic overrideAccess(input logic [15:0] first, input logic [15:0] second);
    int waits = 0;
    int exp = expWaits(second);
    @(negedge clk); busAddr = first; busStrobe = 1'b1;
    @(negedge clk); @(negedge clk);
    @(negedge clk); busStrobe = 1'b0;
    #1 check(ready == 1'b0, "R8", int'(ready), 0);
    @(negedge clk); busAddr = second; busStrobe = 1'b1;
    #1;
    while (!ready && waits < 40) begin
      waits++;
      @(negedge clk); #1;
    end
    check(waits == exp, "R8", waits, exp);
    @(negedge clk); #1;
    check(ready == 1'b1, "R8", int'(ready), 1);
    busStrobe = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5121));
    #1 rstN = 1'b0;
    repeat (2) @(negedge clk);
    #1 check(ready == 1'b1, "R1", int'(ready), 1);

    resetLoad(3, 0, 15, 7);
    doAccess(16'h8123, 4, "R3");   // region 0, 3 waits
    doAccess(16'h8FFF, 0, "R6");   // overlaps region 3: region 0 wins
    doAccess(16'h9000, 2, "R4");   // count 0
    doAccess(16'h3456, 2, "R5");   // no region
    doAccess(16'hB010, 3, "R9");   // region 2 via mask, 15 waits
    doAccess(16'hA777, 0, "R6");   // region 2 base
    doAccess(16'hD000, 2, "R6");   // region 3 only, 7 waits
    doAccess(16'hF0F0, 0, "R6");   // region 3 only

    // R7: writes outside reset are ignored
    @(negedge clk); initWrEn = 1'b1; initIdx = 2'd0; initCount = 4'd12;
    @(negedge clk); initWrEn = 1'b0;
    doAccess(16'h8000, 0, "R7");

    resetLoad(10, 5, 1, 2);
    doAccess(16'hA000, 1, "R3");   // single wait
    overrideAccess(16'h8000, 16'h9000);  // R8 reload with 5
    overrideAccess(16'h8000, 16'h1000);  // R8 miss clears
    overrideAccess(16'h8000, 16'hC000);  // R8 reload with 2

    for (int r = 0; r < 3; r++) begin
      resetLoad(int'($urandom_range(15)), int'($urandom_range(15)),
                int'($urandom_range(15)), int'($urandom_range(15)));
      for (int n = 0; n < 30; n++)
        doAccess(16'($urandom), int'($urandom_range(2)), "R3");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule